// File: doc/BRIEF.md
# Dual-Converter Serial ADC Front End

This block sits between a byte-wide host register bus and two serial analog-to-digital converters, each with eight inputs. Every converter has its own four-byte register window. The second window starts four bytes above the first, so the pair gives sixteen channels. A host write of a command byte to a window starts one full-duplex serial exchange on that converter's link. The 8-bit command goes out on the data-out line. At the same time, the 16-bit result of the previous conversion comes back on the data-in line. When the exchange ends, the result is held in two readable bytes and a ready flag rises in the window's status byte.

The converter pipelines its work, so the result from any exchange belongs to the command sent in the exchange before it. After the host changes channel or range, the first result it gets back is stale and should be thrown away. The command byte packs four fields: bit 7 chooses single-ended input, bit 6 chooses the odd member of a channel pair, bits 5:4 give the pair number, and bits 3:2 give the input span. In bipolar spans the returned word is two's complement. The front end passes the bits through unchanged and does not interpret them.

Each link is SPI-like. The chip select is active low, data goes MSB first, the outgoing bit changes on the falling serial clock, and the incoming bit is sampled on the rising serial clock. The serial clock is the system clock divided by the even parameter `CLK_DIV`.

Top module: `serial_adc_frontend`

## Requirements
- R1: After reset, every window reads 0 at offsets 0, 1 and 3, all chip selects are high and all serial clocks are low.
- R2: A write to offset 2 of window w (bus address w*4+2) holds chip select w low for exactly 16*CLK_DIV clock cycles, starting at the clock edge that takes the write. Chip selects of the other windows do not move.
- R3: During an exchange the data-out line carries the command byte MSB first on the first 8 rising serial clock edges, then zeros on the remaining 8.
- R4: The data-in line is sampled on 16 rising serial clock edges, MSB first. The assembled word is read back with bits 7:0 at offset 0 and bits 15:8 at offset 1.
- R5: The status byte at offset 3 has the ready flag in bit 7 and zeros in all other bits. An accepted command write clears the ready flag. The flag is set at the same edge where chip select returns high, 16*CLK_DIV cycles after the write.
- R6: While an exchange is running, offsets 0 and 1 keep returning the previous result.
- R7: A command write to a window whose exchange is still running is ignored. The exchange, its command and its timing are unchanged.
- R8: Writes to offsets 0, 1 and 3 change no register and start no exchange.
- R9: The two windows run independently. Exchanges on both links may overlap, and each delivers its own result.
- R10: Each serial clock idles low while its chip select is high. During an exchange it gives exactly 16 rising edges, with half periods of CLK_DIV/2 clock cycles.
- R11: Reading offset 2 returns the last accepted command byte of that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address: upper bits pick the window, bits 1:0 the offset |
| bus_wr | input | 1 | Write strobe for one clock cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| adc_sclk | output | NUM_ADC | Serial clock per converter |
| adc_cs_n | output | NUM_ADC | Active-low chip select per converter |
| adc_mosi | output | NUM_ADC | Command bits to each converter |
| adc_miso | input | NUM_ADC | Result bits from each converter |

## Verification
The assertions check the link rules on every cycle. Each serial clock stays low outside its chip select. Chip select falls only after a command write to that window, and it stays low for exactly 16*CLK_DIV cycles. The ready flag rises together with chip select and is never high during an exchange. The result bytes do not change while an exchange is running. Other properties can only be shown by the bench scenarios running against its converter model: the bit order on both data lines, the one-exchange lag between a command and its result, the fact that writes during an exchange or to other offsets are ignored, and overlapping exchanges on both links.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;

    localparam int XFER_BITS = 16;
    localparam int CMD_BITS  = 8;
    localparam int READY_BIT = 7;

    typedef enum logic [1:0] {
        OFS_RES_LO = 2'd0,
        OFS_RES_HI = 2'd1,
        OFS_CMD    = 2'd2,
        OFS_STAT   = 2'd3
    } reg_ofs_e;

    typedef struct packed {
        logic       single_ended;
        logic       odd_sel;
        logic [1:0] pair_idx;
        logic [1:0] span;
        logic [1:0] spare;
    } adc_cmd_t;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_RUN  = 1'b1
    } shift_state_e;

    function automatic logic [7:0] status_byte(input logic ready);
        logic [7:0] s;
        s            = '0;
        s[READY_BIT] = ready;
        return s;
    endfunction

endpackage

// File: rtl/adc_fe_shifter.sv
module adc_fe_shifter
    import adc_fe_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [CMD_BITS-1:0]  cmd,
    output logic                 busy,
    output logic                 finish,
    output logic [XFER_BITS-1:0] rx_word,
    output logic                 sclk,
    output logic                 cs_n,
    output logic                 mosi,
    input  logic                 miso
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BIT_W = $clog2(XFER_BITS);

    shift_state_e         state;
    logic [CNT_W-1:0]     div_cnt;
    logic [BIT_W-1:0]     bit_cnt;
    logic [XFER_BITS-1:0] tx_sr;
    logic [XFER_BITS-1:0] rx_sr;
    logic                 sclk_q;
    logic                 cs_q;
    logic                 half_tick;

    assign half_tick = (state == SH_RUN) && (div_cnt == CNT_W'(HALF - 1));
    assign finish    = half_tick && sclk_q && (bit_cnt == BIT_W'(XFER_BITS - 1));
    assign busy      = (state == SH_RUN);
    assign rx_word   = rx_sr;
    assign sclk      = sclk_q;
    assign cs_n      = cs_q;
    assign mosi      = tx_sr[XFER_BITS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SH_IDLE;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            sclk_q  <= 1'b0;
            cs_q    <= 1'b1;
        end else begin
            case (state)
                SH_IDLE: begin
                    if (start) begin
                        state   <= SH_RUN;
                        cs_q    <= 1'b0;
                        sclk_q  <= 1'b0;
                        div_cnt <= '0;
                        bit_cnt <= '0;
                        tx_sr   <= {cmd, {(XFER_BITS - CMD_BITS){1'b0}}};
                    end
                end
                SH_RUN: begin
                    if (half_tick) begin
                        div_cnt <= '0;
                        sclk_q  <= ~sclk_q;
                        if (!sclk_q) begin
                            rx_sr <= {rx_sr[XFER_BITS-2:0], miso};
                        end else begin
                            tx_sr <= {tx_sr[XFER_BITS-2:0], 1'b0};
                            if (finish) begin
                                state <= SH_IDLE;
                                cs_q  <= 1'b1;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_fe_window.sv
module adc_fe_window
    import adc_fe_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [1:0]           ofs,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    output logic                 ready,
    output logic [XFER_BITS-1:0] result,
    output logic                 sclk,
    output logic                 cs_n,
    output logic                 mosi,
    input  logic                 miso
);
    adc_cmd_t             cmd_q;
    logic [XFER_BITS-1:0] result_q;
    logic                 ready_q;
    logic                 busy;
    logic                 finish;
    logic                 start;
    logic [XFER_BITS-1:0] rx_word;

    assign start  = wr_en && (reg_ofs_e'(ofs) == OFS_CMD) && !busy;
    assign ready  = ready_q;
    assign result = result_q;

    adc_fe_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cmd     (wdata),
        .busy    (busy),
        .finish  (finish),
        .rx_word (rx_word),
        .sclk    (sclk),
        .cs_n    (cs_n),
        .mosi    (mosi),
        .miso    (miso)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= '0;
            result_q <= '0;
            ready_q  <= 1'b0;
        end else if (start) begin
            cmd_q   <= adc_cmd_t'(wdata);
            ready_q <= 1'b0;
        end else if (finish) begin
            result_q <= rx_word;
            ready_q  <= 1'b1;
        end
    end

    always_comb begin
        case (reg_ofs_e'(ofs))
            OFS_RES_LO: rdata = result_q[7:0];
            OFS_RES_HI: rdata = result_q[15:8];
            OFS_CMD:    rdata = cmd_q;
            default:    rdata = status_byte(ready_q);
        endcase
    end

endmodule

// File: rtl/serial_adc_frontend.sv
module serial_adc_frontend
    import adc_fe_pkg::*;
#(
    parameter int NUM_ADC = 2,
    parameter int CLK_DIV = 4,
    localparam int SEL_W  = (NUM_ADC > 1) ? $clog2(NUM_ADC) : 1,
    localparam int ADDR_W = SEL_W + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    output logic [NUM_ADC-1:0] adc_sclk,
    output logic [NUM_ADC-1:0] adc_cs_n,
    output logic [NUM_ADC-1:0] adc_mosi,
    input  logic [NUM_ADC-1:0] adc_miso
);
    logic [SEL_W-1:0]                   win_sel;
    logic [NUM_ADC-1:0][7:0]            win_rdata;
    logic [NUM_ADC-1:0]                 win_ready;
    logic [NUM_ADC-1:0][XFER_BITS-1:0]  win_result;

    assign win_sel = bus_addr[ADDR_W-1:2];

    generate
        if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
            $error("CLK_DIV must be even and at least 2");
        end
        for (genvar i = 0; i < NUM_ADC; i++) begin : g_win
            logic win_wr;
            assign win_wr = bus_wr && (win_sel == SEL_W'(i));
            adc_fe_window #(.CLK_DIV(CLK_DIV)) u_win (
                .clk    (clk),
                .rst    (rst),
                .wr_en  (win_wr),
                .ofs    (bus_addr[1:0]),
                .wdata  (bus_wdata),
                .rdata  (win_rdata[i]),
                .ready  (win_ready[i]),
                .result (win_result[i]),
                .sclk   (adc_sclk[i]),
                .cs_n   (adc_cs_n[i]),
                .mosi   (adc_mosi[i]),
                .miso   (adc_miso[i])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_ADC; i++) begin
            if (win_sel == SEL_W'(i)) bus_rdata = win_rdata[i];
        end
    end

endmodule

// File: rtl/adc_fe_chk.sv
module adc_fe_chk #(
    parameter int NUM_ADC = 2,
    parameter int CLK_DIV = 4,
    parameter int ADDR_W  = 3
) (
    input logic                      clk,
    input logic                      rst,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic                      bus_wr,
    input logic [NUM_ADC-1:0]        adc_sclk,
    input logic [NUM_ADC-1:0]        adc_cs_n,
    input logic [NUM_ADC-1:0]        ready,
    input logic [NUM_ADC-1:0][15:0]  result
);
    localparam int SEL_W    = ADDR_W - 2;
    localparam int XFER_CYC = 16 * CLK_DIV;

    for (genvar i = 0; i < NUM_ADC; i++) begin : g_chk
        logic [31:0] low_cnt;

        always_ff @(posedge clk) begin
            if (rst || adc_cs_n[i]) low_cnt <= '0;
            else                    low_cnt <= low_cnt + 32'd1;
        end

        // R10
        sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
            adc_cs_n[i] |-> !adc_sclk[i]);

        // R2
        cs_start_by_write_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(adc_cs_n[i]) |-> $past(bus_wr && bus_addr[ADDR_W-1:2] == SEL_W'(i)
                                         && bus_addr[1:0] == 2'd2));

        // R2
        cs_window_max_chk: assert property (@(posedge clk) disable iff (rst)
            low_cnt <= 32'(XFER_CYC));

        // R2
        cs_window_exact_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(adc_cs_n[i]) |-> low_cnt == 32'(XFER_CYC));

        // R5
        ready_with_cs_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(ready[i]) |-> $rose(adc_cs_n[i]));

        // R5
        ready_idle_only_chk: assert property (@(posedge clk) disable iff (rst)
            ready[i] |-> adc_cs_n[i]);

        // R6
        result_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!adc_cs_n[i] && $past(!adc_cs_n[i])) |-> $stable(result[i]));
    end

endmodule

bind serial_adc_frontend adc_fe_chk #(
    .NUM_ADC (NUM_ADC),
    .CLK_DIV (CLK_DIV),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .adc_sclk (adc_sclk),
    .adc_cs_n (adc_cs_n),
    .ready    (win_ready),
    .result   (win_result)
);

// File: tb/serial_adc_frontend_tb.sv
`timescale 1ns/1ps

module adc_conv_model #(
    parameter int IDX = 0
) (
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        mosi,
    output logic        miso,
    output logic [15:0] got_word
);
    logic [15:0] out_sr;
    logic [15:0] in_sr;
    logic [7:0]  prev_cmd;

    function automatic logic [15:0] conv(input int idx, input logic [7:0] c);
        return {c ^ ((idx != 0) ? 8'h3C : 8'hC3), ~c};
    endfunction

    initial begin
        out_sr   = '0;
        in_sr    = '0;
        prev_cmd = '0;
        got_word = '0;
    end

    assign miso = out_sr[15];

    always @(negedge cs_n) begin
        out_sr = conv(IDX, prev_cmd);
        in_sr  = '0;
    end
    always @(posedge sclk) in_sr = {in_sr[14:0], mosi};
    always @(negedge sclk) out_sr = {out_sr[14:0], 1'b0};
    always @(posedge cs_n) begin
        got_word = in_sr;
        prev_cmd = in_sr[15:8];
    end
endmodule

module serial_adc_frontend_tb;
    localparam int NUM_ADC  = 2;
    localparam int DIV      = 4;
    localparam int XFER_CYC = 16 * DIV;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [2:0]         bus_addr = '0;
    logic               bus_wr = 1'b0;
    logic [7:0]         bus_wdata = '0;
    logic [7:0]         bus_rdata;
    logic [NUM_ADC-1:0] adc_sclk, adc_cs_n, adc_mosi, adc_miso;
    logic [15:0]        got0, got1;

    int checks = 0;
    int errors = 0;
    int rise0  = 0;
    logic [7:0] exp_prev [NUM_ADC];

    always #2 clk = ~clk;

    serial_adc_frontend #(.NUM_ADC(NUM_ADC), .CLK_DIV(DIV)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adc_sclk(adc_sclk),
        .adc_cs_n(adc_cs_n), .adc_mosi(adc_mosi), .adc_miso(adc_miso)
    );

    adc_conv_model #(.IDX(0)) u_m0 (.sclk(adc_sclk[0]), .cs_n(adc_cs_n[0]),
        .mosi(adc_mosi[0]), .miso(adc_miso[0]), .got_word(got0));
    adc_conv_model #(.IDX(1)) u_m1 (.sclk(adc_sclk[1]), .cs_n(adc_cs_n[1]),
        .mosi(adc_mosi[1]), .miso(adc_miso[1]), .got_word(got1));

    always @(posedge adc_sclk[0]) rise0++;

    function automatic logic [15:0] exp_conv(input int idx, input logic [7:0] c);
        return {c ^ ((idx != 0) ? 8'h3C : 8'hC3), ~c};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic bus_write(input int win, input logic [1:0] ofs, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = {win[0], ofs};
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input int win, input logic [1:0] ofs, output logic [7:0] d);
        bus_addr = {win[0], ofs};
        #1;
        d = bus_rdata;
    endtask

    task automatic read_result(input int win, output logic [15:0] r);
        logic [7:0] lo, hi;
        bus_read(win, 2'd0, lo);
        bus_read(win, 2'd1, hi);
        r = {hi, lo};
    endtask

    task automatic wait_ready(input int win, input string req);
        logic [7:0] s;
        for (int k = 0; k < 2 * XFER_CYC; k++) begin
            bus_read(win, 2'd3, s);
            if (s[7]) return;
            @(negedge clk);
        end
        check(req, 32'h0, 32'h80);
    endtask

    task automatic cmd_and_check(input int win, input logic [7:0] c, input string req);
        logic [15:0] r;
        logic [15:0] g;
        logic [15:0] e;
        e = exp_conv(win, exp_prev[win]);
        bus_write(win, 2'd2, c);
        exp_prev[win] = c;
        wait_ready(win, req);
        @(negedge clk);
        read_result(win, r);
        check(req, r, e);
        g = (win == 0) ? got0 : got1;
        check(req, g, {c, 8'h00});
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] r;
        int          rbase;
        void'($urandom(32'd20240611));
        exp_prev[0] = '0;
        exp_prev[1] = '0;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int w = 0; w < NUM_ADC; w++) begin
            bus_read(w, 2'd0, d); check("R1 lo", d, 8'h00);
            bus_read(w, 2'd1, d); check("R1 hi", d, 8'h00);
            bus_read(w, 2'd3, d); check("R1 status", d, 8'h00);
        end
        check("R1 cs_n", adc_cs_n, 2'b11);
        check("R1 sclk", adc_sclk, 2'b00);

        // Directed exchange with exact timing (R2, R3, R4, R5, R10, R11)
        rbase = rise0;
        bus_write(0, 2'd2, 8'h8C);
        bus_read(0, 2'd3, d); check("R5 cleared", d, 8'h00);
        check("R2 cs low", adc_cs_n, 2'b10);
        repeat (XFER_CYC - 1) @(negedge clk);
        bus_read(0, 2'd3, d); check("R5 not yet", d, 8'h00);
        check("R2 still low", adc_cs_n[0], 1'b0);
        @(negedge clk);
        bus_read(0, 2'd3, d); check("R5 ready", d, 8'h80);
        check("R2 cs high", adc_cs_n[0], 1'b1);
        check("R10 rises", rise0 - rbase, 16);
        read_result(0, r); check("R4 result", r, exp_conv(0, 8'h00));
        check("R3 mosi", got0, 16'h8C00);
        bus_read(0, 2'd2, d); check("R11 readback", d, 8'h8C);
        exp_prev[0] = 8'h8C;

        // R7 busy write ignored, R6 result held during exchange
        bus_write(0, 2'd2, 8'h41);
        repeat (10) @(negedge clk);
        bus_write(0, 2'd2, 8'hFF);
        bus_read(0, 2'd2, d); check("R7 cmd kept", d, 8'h41);
        read_result(0, r); check("R6 held", r, exp_conv(0, 8'h00));
        wait_ready(0, "R7 ready");
        @(negedge clk);
        read_result(0, r); check("R4 lag", r, exp_conv(0, 8'h8C));
        check("R7 sent cmd", got0, 16'h4100);
        exp_prev[0] = 8'h41;
        repeat (3) @(negedge clk);
        check("R7 no restart", adc_cs_n[0], 1'b1);

        // R8 writes to other offsets ignored
        bus_write(0, 2'd0, 8'h5A);
        bus_write(0, 2'd1, 8'hA5);
        bus_write(0, 2'd3, 8'h00);
        @(negedge clk);
        read_result(0, r); check("R8 result", r, exp_conv(0, 8'h8C));
        bus_read(0, 2'd3, d); check("R8 status", d, 8'h80);
        check("R8 no exchange", adc_cs_n, 2'b11);

        // R9 overlapping exchanges on both windows
        bus_write(0, 2'd2, 8'h9D);
        bus_write(1, 2'd2, 8'h26);
        check("R9 both low", adc_cs_n, 2'b00);
        wait_ready(0, "R9 ready0");
        wait_ready(1, "R9 ready1");
        @(negedge clk);
        read_result(0, r); check("R9 result0", r, exp_conv(0, 8'h41));
        read_result(1, r); check("R9 result1", r, exp_conv(1, 8'h00));
        check("R9 mosi0", got0, 16'h9D00);
        check("R9 mosi1", got1, 16'h2600);
        exp_prev[0] = 8'h9D;
        exp_prev[1] = 8'h26;

        // Random commands on random windows (R3, R4, R7)
        for (int n = 0; n < 40; n++) begin
            int          w;
            logic [7:0]  c;
            logic [15:0] e;
            w = $urandom % NUM_ADC;
            c = 8'($urandom);
            if (($urandom % 4) == 0) begin
                e = exp_conv(w, exp_prev[w]);
                bus_write(w, 2'd2, c);
                exp_prev[w] = c;
                repeat ($urandom % 30 + 1) @(negedge clk);
                bus_write(w, 2'd2, ~c);
                bus_read(w, 2'd2, d); check("R7 random", d, c);
                wait_ready(w, "R7 random ready");
                @(negedge clk);
                read_result(w, r); check("R4 random busy", r, e);
            end else begin
                cmd_and_check(w, c, "R4 random");
            end
        end

        finish_run();
    end
endmodule